// File: doc/BRIEF.md
# DRAM Command Injection Register Block

This block sits in front of a DFI-style DRAM command interface and decides who drives it. While software owns the interface, a small set of word-addressed registers holds the clock-enable, on-die-termination and DRAM-reset levels, plus a row address, a bank address and four command bits. A write to the strobe word places the stored command on the active-low command pins for exactly one clock. In every other cycle the pins rest at NOP. This lets boot firmware bring a memory device up by hand: it can pulse CKE, load mode registers and issue precharges.

When firmware sets the select bit, every DFI output follows a pass-through port fed by the hardware memory controller, and strobes are ignored. A two-state machine handles the launch. `ST_IDLE` moves to `ST_FIRE` on an accepted strobe, with the transition named *launch*. `ST_FIRE` returns to `ST_IDLE` after one cycle (*retire*), or stays in `ST_FIRE` when another accepted strobe arrives in that same cycle (*relaunch*). The output process decodes that state together with the select bit.

Top module: `dfi_inject_regs`

## Requirements
- R1: After reset the control word is 0. Software owns the interface, `dfi_cke`, `dfi_odt` and `dfi_reset_n` are low, all four active-low command pins are high (NOP), and address and bank are 0.
- R2: With select clear, a write to word index 0 sets the control levels: bit 1 drives `dfi_cke`, bit 2 drives `dfi_odt` and bit 3 drives `dfi_reset_n`, from the cycle after the write edge. CKE can be lowered and raised again while ODT and RESET_N stay high.
- R3: The command word (index 1) is stored active-high, with bit 0 = CS, bit 1 = WE, bit 2 = CAS and bit 3 = RAS. During a launched cycle each set bit drives its pin low. With 0x0F all four pins are low; with 0x03 only `dfi_cs_n` and `dfi_we_n` are low.
- R4: A write of bit 0 = 1 to index 2 with select clear puts the stored command on the pins in the single cycle after the write edge. The pins are NOP in the next cycle.
- R5: A write to index 2 with bit 0 = 0 launches nothing, and the pins stay NOP.
- R6: Index 3 holds the row address (low `ROW_W` bits of the written data) and index 4 holds the bank (low `BANK_W` bits). With select clear, both appear on `dfi_addr` and `dfi_bank` from the cycle after the write edge.
- R7: With control bit 0 set, every DFI output equals the matching `mc_*` input in the same cycle.
- R8: A strobe written while select is set is dropped. Once select is cleared again, the pins are NOP.
- R9: Strobes written on two consecutive edges give two consecutive command cycles, then NOP.
- R10: Writing the command word alone does not launch it; the pins stay NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Word index of the register written |
| reg_wdata | input | 32 | Write data |
| mc_cke | input | 1 | Controller CKE |
| mc_odt | input | 1 | Controller ODT |
| mc_reset_n | input | 1 | Controller DRAM reset |
| mc_cs_n | input | 1 | Controller chip select, active low |
| mc_we_n | input | 1 | Controller write enable, active low |
| mc_cas_n | input | 1 | Controller CAS, active low |
| mc_ras_n | input | 1 | Controller RAS, active low |
| mc_addr | input | ROW_W | Controller address |
| mc_bank | input | BANK_W | Controller bank |
| dfi_cke | output | 1 | Clock enable to PHY |
| dfi_odt | output | 1 | On-die termination to PHY |
| dfi_reset_n | output | 1 | DRAM reset to PHY |
| dfi_cs_n | output | 1 | Chip select to PHY |
| dfi_we_n | output | 1 | Write enable to PHY |
| dfi_cas_n | output | 1 | CAS to PHY |
| dfi_ras_n | output | 1 | RAS to PHY |
| dfi_addr | output | ROW_W | Address to PHY |
| dfi_bank | output | BANK_W | Bank to PHY |

## Verification
Two functions can meet in one cycle. The first is a new strobe arriving while the previous command is still on the pins: the bench writes the strobe on two consecutive edges and expects exactly two command cycles followed by NOP, which exercises the *relaunch* transition. The second is a strobe arriving while the controller owns the interface: the bench writes the strobe with select set, expects the outputs to keep following the `mc_*` pattern, and then, after clearing select, expects NOP with no late launch.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } fire_state_e;

    // Command word layout: CS in bit 0 up to RAS in bit 3
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic cs;
    } cmd_bits_t;

    // Control word layout: select in bit 0 up to reset in bit 3
    typedef struct packed {
        logic rst;
        logic odt;
        logic cke;
        logic sel;
    } ctrl_bits_t;

    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_CMD   = 1;
    localparam int unsigned IDX_ISSUE = 2;
    localparam int unsigned IDX_ADDR  = 3;
    localparam int unsigned IDX_BANK  = 4;

endpackage

// File: rtl/dfi_inj_regfile.sv
module dfi_inj_regfile
    import dfi_inj_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    output ctrl_bits_t        ctrl_q,
    output cmd_bits_t         cmd_q,
    output logic [ROW_W-1:0]  addr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              strobe
);

    localparam int CMD_W  = $bits(cmd_bits_t);
    localparam int CTRL_W = $bits(ctrl_bits_t);

    logic hit_ctrl, hit_cmd, hit_issue, hit_addr, hit_bank;

    always_comb begin
        hit_ctrl  = reg_we && (reg_idx == IDX_W'(IDX_CTRL));
        hit_cmd   = reg_we && (reg_idx == IDX_W'(IDX_CMD));
        hit_issue = reg_we && (reg_idx == IDX_W'(IDX_ISSUE));
        hit_addr  = reg_we && (reg_idx == IDX_W'(IDX_ADDR));
        hit_bank  = reg_we && (reg_idx == IDX_W'(IDX_BANK));
    end

    // The strobe word has no storage; only bit 0 matters
    assign strobe = hit_issue && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            bank_q <= '0;
        end else begin
            if (hit_ctrl) ctrl_q <= ctrl_bits_t'(reg_wdata[CTRL_W-1:0]);
            if (hit_cmd)  cmd_q  <= cmd_bits_t'(reg_wdata[CMD_W-1:0]);
            if (hit_addr) addr_q <= reg_wdata[ROW_W-1:0];
            if (hit_bank) bank_q <= reg_wdata[BANK_W-1:0];
        end
    end

endmodule

// File: rtl/dfi_inj_fsm.sv
module dfi_inj_fsm
    import dfi_inj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sel,
    output logic fire
);

    fire_state_e state_q, state_d;
    logic        accept;

    assign accept = strobe && !sel;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_FIRE;   // launch
            ST_FIRE: state_d = accept ? ST_FIRE       // relaunch
                                      : ST_IDLE;      // retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign fire = (state_q == ST_FIRE);

endmodule

// File: rtl/dfi_inj_mux.sv
module dfi_inj_mux
    import dfi_inj_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3
) (
    input  ctrl_bits_t        ctrl_q,
    input  cmd_bits_t         cmd_q,
    input  logic [ROW_W-1:0]  addr_q,
    input  logic [BANK_W-1:0] bank_q,
    input  logic              fire,
    input  logic              mc_cke,
    input  logic              mc_odt,
    input  logic              mc_reset_n,
    input  logic              mc_cs_n,
    input  logic              mc_we_n,
    input  logic              mc_cas_n,
    input  logic              mc_ras_n,
    input  logic [ROW_W-1:0]  mc_addr,
    input  logic [BANK_W-1:0] mc_bank,
    output logic              dfi_cke,
    output logic              dfi_odt,
    output logic              dfi_reset_n,
    output logic              dfi_cs_n,
    output logic              dfi_we_n,
    output logic              dfi_cas_n,
    output logic              dfi_ras_n,
    output logic [ROW_W-1:0]  dfi_addr,
    output logic [BANK_W-1:0] dfi_bank
);

    always_comb begin
        if (ctrl_q.sel) begin
            dfi_cke     = mc_cke;
            dfi_odt     = mc_odt;
            dfi_reset_n = mc_reset_n;
            dfi_cs_n    = mc_cs_n;
            dfi_we_n    = mc_we_n;
            dfi_cas_n   = mc_cas_n;
            dfi_ras_n   = mc_ras_n;
            dfi_addr    = mc_addr;
            dfi_bank    = mc_bank;
        end else begin
            dfi_cke     = ctrl_q.cke;
            dfi_odt     = ctrl_q.odt;
            dfi_reset_n = ctrl_q.rst;
            dfi_cs_n    = ~(fire & cmd_q.cs);
            dfi_we_n    = ~(fire & cmd_q.we);
            dfi_cas_n   = ~(fire & cmd_q.cas);
            dfi_ras_n   = ~(fire & cmd_q.ras);
            dfi_addr    = addr_q;
            dfi_bank    = bank_q;
        end
    end

endmodule

// File: rtl/dfi_inject_regs.sv
module dfi_inject_regs
    import dfi_inj_pkg::*;
#(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [31:0]       reg_wdata,
    input  logic              mc_cke,
    input  logic              mc_odt,
    input  logic              mc_reset_n,
    input  logic              mc_cs_n,
    input  logic              mc_we_n,
    input  logic              mc_cas_n,
    input  logic              mc_ras_n,
    input  logic [ROW_W-1:0]  mc_addr,
    input  logic [BANK_W-1:0] mc_bank,
    output logic              dfi_cke,
    output logic              dfi_odt,
    output logic              dfi_reset_n,
    output logic              dfi_cs_n,
    output logic              dfi_we_n,
    output logic              dfi_cas_n,
    output logic              dfi_ras_n,
    output logic [ROW_W-1:0]  dfi_addr,
    output logic [BANK_W-1:0] dfi_bank
);

    ctrl_bits_t        ctrl_q;
    cmd_bits_t         cmd_q;
    logic [ROW_W-1:0]  addr_q;
    logic [BANK_W-1:0] bank_q;
    logic              strobe;
    logic              fire;
    logic              sel_w;

    assign sel_w = ctrl_q.sel;

    dfi_inj_regfile #(.ROW_W(ROW_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .cmd_q(cmd_q),
        .addr_q(addr_q), .bank_q(bank_q), .strobe(strobe)
    );

    dfi_inj_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel(sel_w), .fire(fire)
    );

    dfi_inj_mux #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_mux (
        .ctrl_q(ctrl_q), .cmd_q(cmd_q), .addr_q(addr_q), .bank_q(bank_q),
        .fire(fire),
        .mc_cke(mc_cke), .mc_odt(mc_odt), .mc_reset_n(mc_reset_n),
        .mc_cs_n(mc_cs_n), .mc_we_n(mc_we_n), .mc_cas_n(mc_cas_n),
        .mc_ras_n(mc_ras_n), .mc_addr(mc_addr), .mc_bank(mc_bank),
        .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n),
        .dfi_cs_n(dfi_cs_n), .dfi_we_n(dfi_we_n), .dfi_cas_n(dfi_cas_n),
        .dfi_ras_n(dfi_ras_n), .dfi_addr(dfi_addr), .dfi_bank(dfi_bank)
    );

endmodule

// File: rtl/dfi_inj_checks.sv
module dfi_inj_checks #(
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [31:0]       reg_wdata,
    input logic              mc_cke,
    input logic              mc_odt,
    input logic              mc_reset_n,
    input logic              mc_cs_n,
    input logic              mc_we_n,
    input logic              mc_cas_n,
    input logic              mc_ras_n,
    input logic [ROW_W-1:0]  mc_addr,
    input logic [BANK_W-1:0] mc_bank,
    input logic              dfi_cke,
    input logic              dfi_odt,
    input logic              dfi_reset_n,
    input logic              dfi_cs_n,
    input logic              dfi_we_n,
    input logic              dfi_cas_n,
    input logic              dfi_ras_n,
    input logic [ROW_W-1:0]  dfi_addr,
    input logic [BANK_W-1:0] dfi_bank
);

    logic go_wr, ctrl_wr, addr_wr, bank_wr;
    assign go_wr   = reg_we && (reg_idx == IDX_W'(2)) && reg_wdata[0];
    assign ctrl_wr = reg_we && (reg_idx == IDX_W'(0));
    assign addr_wr = reg_we && (reg_idx == IDX_W'(3));
    assign bank_wr = reg_we && (reg_idx == IDX_W'(4));

    // R4: an active chip select under software needs a strobe one edge earlier
    a_r4_fire_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !dfi_cs_n) |-> $past(go_wr && !sel));

    // R1, R10: without a strobe on the previous edge the pins are NOP
    a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(go_wr)) |-> (dfi_cs_n && dfi_we_n && dfi_cas_n && dfi_ras_n));

    // R7: the controller port owns every output while select is set
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (dfi_cke == mc_cke && dfi_odt == mc_odt && dfi_reset_n == mc_reset_n &&
                 dfi_cs_n == mc_cs_n && dfi_we_n == mc_we_n && dfi_cas_n == mc_cas_n &&
                 dfi_ras_n == mc_ras_n && dfi_addr == mc_addr && dfi_bank == mc_bank));

    // R2: control levels move only after a control write
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel) && !$past(ctrl_wr)) |->
            ($stable(dfi_cke) && $stable(dfi_odt) && $stable(dfi_reset_n)));

    // R6: address and bank move only after their own writes
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel) && !$past(addr_wr)) |-> $stable(dfi_addr));
    a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel) && !$past(bank_wr)) |-> $stable(dfi_bank));

endmodule

bind dfi_inject_regs dfi_inj_checks #(.ROW_W(ROW_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel_w),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .mc_cke(mc_cke), .mc_odt(mc_odt), .mc_reset_n(mc_reset_n),
    .mc_cs_n(mc_cs_n), .mc_we_n(mc_we_n), .mc_cas_n(mc_cas_n),
    .mc_ras_n(mc_ras_n), .mc_addr(mc_addr), .mc_bank(mc_bank),
    .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n),
    .dfi_cs_n(dfi_cs_n), .dfi_we_n(dfi_we_n), .dfi_cas_n(dfi_cas_n),
    .dfi_ras_n(dfi_ras_n), .dfi_addr(dfi_addr), .dfi_bank(dfi_bank)
);

// File: tb/tb_dfi_inject_regs.sv
`timescale 1ns/100ps
module tb_dfi_inject_regs;

    localparam int ROW_W  = 15;
    localparam int BANK_W = 3;
    localparam int IDX_W  = 3;
    localparam int VW     = 7 + ROW_W + BANK_W;

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic mc_cke = 0, mc_odt = 0, mc_reset_n = 0;
    logic mc_cs_n = 1, mc_we_n = 1, mc_cas_n = 1, mc_ras_n = 1;
    logic [ROW_W-1:0] mc_addr = '0;
    logic [BANK_W-1:0] mc_bank = '0;
    logic dfi_cke, dfi_odt, dfi_reset_n, dfi_cs_n, dfi_we_n, dfi_cas_n, dfi_ras_n;
    logic [ROW_W-1:0] dfi_addr;
    logic [BANK_W-1:0] dfi_bank;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    exp_t sb[$];

    // bench-side register model
    logic [3:0] m_ctrl = '0;
    logic [3:0] m_cmd  = '0;
    logic [ROW_W-1:0] m_addr = '0;
    logic [BANK_W-1:0] m_bank = '0;

    always #2.5 clk = ~clk;

    dfi_inject_regs #(.ROW_W(ROW_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .mc_cke(mc_cke), .mc_odt(mc_odt), .mc_reset_n(mc_reset_n),
        .mc_cs_n(mc_cs_n), .mc_we_n(mc_we_n), .mc_cas_n(mc_cas_n), .mc_ras_n(mc_ras_n),
        .mc_addr(mc_addr), .mc_bank(mc_bank),
        .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n),
        .dfi_cs_n(dfi_cs_n), .dfi_we_n(dfi_we_n), .dfi_cas_n(dfi_cas_n), .dfi_ras_n(dfi_ras_n),
        .dfi_addr(dfi_addr), .dfi_bank(dfi_bank)
    );

    function automatic logic [VW-1:0] sw_vec(input bit fire);
        logic [3:0] act;
        act = fire ? m_cmd : 4'h0;
        return {m_ctrl[1], m_ctrl[2], m_ctrl[3], ~act[0], ~act[1], ~act[2], ~act[3], m_addr, m_bank};
    endfunction

    function automatic logic [VW-1:0] mc_vec();
        return {mc_cke, mc_odt, mc_reset_n, mc_cs_n, mc_we_n, mc_cas_n, mc_ras_n, mc_addr, mc_bank};
    endfunction

    task automatic push(input logic [VW-1:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_idx = IDX_W'(idx); reg_wdata = data;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // monitor: one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [VW-1:0] act;
            e = sb.pop_front();
            act = {dfi_cke, dfi_odt, dfi_reset_n, dfi_cs_n, dfi_we_n, dfi_cas_n, dfi_ras_n, dfi_addr, dfi_bank};
            checks++;
            if (act !== e.v) begin
                failures++;
                $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.v);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        push(sw_vec(0), "R1"); drain();

        // R2: bring-up levels, CKE low then high with ODT and RESET_N held
        wr(0, 32'h0E); m_ctrl = 4'hE; push(sw_vec(0), "R2"); drain();
        wr(0, 32'h0C); m_ctrl = 4'hC; push(sw_vec(0), "R2"); drain();
        wr(0, 32'h0E); m_ctrl = 4'hE; push(sw_vec(0), "R2"); drain();

        // R6: address and bank, upper data bits discarded
        wr(3, 32'hFFFF_8200); m_addr = 15'h0200; push(sw_vec(0), "R6"); drain();
        wr(4, 32'hFFFF_FFFA); m_bank = 3'h2; push(sw_vec(0), "R6"); drain();

        // R10: storing a command does not launch it
        wr(1, 32'h0F); m_cmd = 4'hF; push(sw_vec(0), "R10"); push(sw_vec(0), "R10"); drain();

        // R3 / R4: mode-register-set style launch, one cycle then NOP
        wr(2, 32'h1); push(sw_vec(1), "R3"); push(sw_vec(0), "R4"); drain();

        // R3: WE+CS only
        wr(3, 32'h400); m_addr = 15'h0400;
        wr(4, 32'h0); m_bank = 3'h0;
        wr(1, 32'h03); m_cmd = 4'h3; push(sw_vec(0), "R10"); drain();
        wr(2, 32'h1); push(sw_vec(1), "R3"); push(sw_vec(0), "R4"); drain();

        // R5: strobe word with bit 0 clear
        wr(2, 32'hFFFF_FFFE); push(sw_vec(0), "R5"); push(sw_vec(0), "R5"); drain();

        // R9: strobes on consecutive edges
        wr(1, 32'h0C); m_cmd = 4'hC;
        @(posedge clk); #1;
        reg_we = 1'b1; reg_idx = 3'd2; reg_wdata = 32'h1;
        @(posedge clk); #1;
        push(sw_vec(1), "R9");
        @(posedge clk); #1;
        reg_we = 1'b0;
        push(sw_vec(1), "R9"); push(sw_vec(0), "R9"); drain();

        // R7: hand the interface to the controller
        mc_cke = 1; mc_odt = 0; mc_reset_n = 1; mc_cs_n = 0; mc_we_n = 1;
        mc_cas_n = 0; mc_ras_n = 1; mc_addr = 15'h5A5A; mc_bank = 3'h5;
        wr(0, 32'h0F); m_ctrl = 4'hF; push(mc_vec(), "R7"); drain();
        @(posedge clk); #1;
        mc_cke = 0; mc_odt = 1; mc_cs_n = 1; mc_ras_n = 0; mc_addr = 15'h1234; mc_bank = 3'h3;
        push(mc_vec(), "R7"); drain();

        // R8: strobe while the controller owns the pins is dropped
        wr(1, 32'h0F); m_cmd = 4'hF;
        wr(2, 32'h1); push(mc_vec(), "R8"); drain();
        wr(0, 32'h0E); m_ctrl = 4'hE; push(sw_vec(0), "R8"); push(sw_vec(0), "R8"); drain();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule